// File: doc/BRIEF.md
# Microsecond System Timer with Compare Channels

The block is a memory-mapped timer with a 64-bit free-running count. The count advances by one on each clock cycle in which the tick enable input is high. That input is normally a one-cycle pulse per microsecond from a divider outside the block. Software reads the count as two data-width words: the low word first, then the high word. It joins them as `(high << DATA_W) | low`. Reading the low word captures the high word at the same moment, so the pair stays consistent when a carry crosses between the two reads.

Each compare channel holds a data-width compare value. Software arms a channel by adding an interval to the current low word, letting the sum wrap modulo 2^DATA_W, and writing the result. When a tick moves the low word onto a channel's compare value, that channel's match flag is set and stays set. Its interrupt line follows the flag as a level. Software acknowledges a match by writing a 1 to that flag's bit in the status word.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the count is zero. It rises by exactly one at every clock edge where `tick_i` is high and holds its value otherwise.
- R2: A read of word address 1 returns the low word of the count and captures the upper word at the same instant. A read of word address 2 returns the captured upper word. Read data appears on `rdata_o` one cycle after the request, and writes to addresses 1 and 2 have no effect.
- R3: Channel n's compare value lives at word address 4+n. It can be written and read back.
- R4: Flag n is set on the tick edge at which the low word steps onto compare value n. This includes compare values reached only by wrapping past the top of the low word.
- R5: Without a tick the flags are not set, even when a compare value is written equal to the current low word.
- R6: Writing status (word address 0) with bit n = 1 clears flag n. Bits written as 0 leave their flags as they are, and status bits above N_CH-1 are ignored.
- R7: If a match and a clear of the same flag fall on the same edge, the flag stays set. A clear of another flag on that edge still takes effect.
- R8: A read of status returns flag n in bit n, with every bit above N_CH-1 reading as zero.
- R9: `irq_o[n]` equals flag n on every cycle.
- R10: After reset all flags, interrupt lines, compare values and read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advance the count this cycle |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | N_CH | Per-channel interrupt level |

## Verification
The assertions check on every cycle that the count steps by exactly one on a tick and holds its value without one. They also check that an interrupt rises only on a tick edge and falls only after a status write, and that status reads carry zeros above the channel bits. Only the bench scenarios can show the behaviours that depend on specific values: the exact tick on which each channel matches, including matches reached by wrapping past the top of the low word. The same holds for the consistent high-word capture across a carry, for a clear losing to a match on the same edge, and for a compare value written equal to the current count staying silent until a tick. The bench runs these with a narrow data width, which keeps the rollover cases short.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
  localparam int unsigned OFF_STATUS   = 0;
  localparam int unsigned OFF_CNT_LO   = 1;
  localparam int unsigned OFF_CNT_HI   = 2;
  localparam int unsigned OFF_CMP_BASE = 4;
endpackage

// File: rtl/stimer_counter.sv
module stimer_counter #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] nxt_lo_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign cnt_o    = cnt_q;
  assign nxt_lo_o = cnt_nxt[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/stimer_channel.sv
module stimer_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] nxt_lo_i,
  input  logic              cmp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] cmp_q;
  logic              flag_q;
  logic              hit;

  // match only when the low word steps onto the compare value
  assign hit = tick_i && (nxt_lo_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cmp_we_i) cmp_q <= wdata_i;
      if (hit)         flag_q <= 1'b1;  // set beats clear
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stimer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_w;
  logic [DATA_W-1:0] nxt_lo;
  logic [DATA_W-1:0] cmp_w [N_CH];
  logic [N_CH-1:0]   flag_w;
  logic [DATA_W-1:0] hi_snap_q, rdata_q, rd_nxt;
  logic              rd_en, wr_en, sel_status, sel_lo, sel_hi;

  assign rd_en      = req_i && !we_i;
  assign wr_en      = req_i && we_i;
  assign sel_status = (addr_i == ADDR_W'(OFF_STATUS));
  assign sel_lo     = (addr_i == ADDR_W'(OFF_CNT_LO));
  assign sel_hi     = (addr_i == ADDR_W'(OFF_CNT_HI));

  stimer_counter #(.DATA_W(DATA_W)) i_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cnt_o    (cnt_w),
    .nxt_lo_o (nxt_lo)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic cmp_we, clr;
    assign cmp_we = wr_en && (addr_i == ADDR_W'(OFF_CMP_BASE + k));
    assign clr    = wr_en && sel_status && wdata_i[k];

    stimer_channel #(.DATA_W(DATA_W)) i_channel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .nxt_lo_i (nxt_lo),
      .cmp_we_i (cmp_we),
      .wdata_i  (wdata_i),
      .clr_i    (clr),
      .cmp_o    (cmp_w[k]),
      .flag_o   (flag_w[k])
    );
  end

  always_comb begin
    rd_nxt = '0;
    if (sel_status) rd_nxt = {{(DATA_W-N_CH){1'b0}}, flag_w};
    if (sel_lo)     rd_nxt = cnt_w[DATA_W-1:0];
    if (sel_hi)     rd_nxt = hi_snap_q;
    for (int k = 0; k < N_CH; k++) begin
      if (addr_i == ADDR_W'(OFF_CMP_BASE + k)) rd_nxt = cmp_w[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      hi_snap_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_nxt;
      if (sel_lo) hi_snap_q <= cnt_w[CNT_W-1:DATA_W];
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = flag_w;
endmodule

// File: rtl/stimer_chk.sv
module stimer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_CH-1:0]   irq_o,
  input logic [CNT_W-1:0]  cnt_q
);
  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i) |-> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r1_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(cnt_q));

  a_r5_irq_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_o & ~$past(irq_o))) |-> $past(tick_i));

  a_r6_irq_fall_on_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(irq_o) & ~irq_o)) |-> $past(req_i && we_i && addr_i == '0));

  a_r8_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && addr_i == '0) |-> rdata_o[DATA_W-1:N_CH] == '0);
endmodule

bind sys_tick_timer stimer_chk #(
  .DATA_W(DATA_W), .N_CH(N_CH), .ADDR_W(ADDR_W)
) i_stimer_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .cnt_q   (cnt_w)
);

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  localparam int unsigned DW = 8;
  localparam int unsigned NC = 4;
  localparam int unsigned AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NC-1:0] irq;

  int            n_chk = 0, n_bad = 0;
  bit            done = 0;
  logic [15:0]   cnt_m = '0;
  logic [DW-1:0] cmp_m [NC];
  logic [NC-1:0] flg_m = '0;

  always #10 clk = ~clk;

  sys_tick_timer #(.DATA_W(DW), .N_CH(NC), .ADDR_W(AW)) i_sys_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_matches();
    for (int k = 0; k < NC; k++) if (cnt_m[DW-1:0] == cmp_m[k]) flg_m[k] = 1'b1;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == 0) flg_m &= ~d[NC-1:0];
    if (a >= 4) cmp_m[a-4] = d;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    cnt_m++;
    apply_matches();
  endtask

  task automatic tick_clr(input logic [DW-1:0] d);
    @(negedge clk); tick = 1; req = 1; we = 1; addr = 0; wdata = d;
    @(negedge clk); tick = 0; req = 0; we = 0;
    cnt_m++;
    flg_m &= ~d[NC-1:0];
    apply_matches();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, hsnap;
    logic [DW-1:0] iv [NC];
    iv[0] = 8'h05; iv[1] = 8'h30; iv[2] = 8'h80; iv[3] = 8'hF0;
    for (int k = 0; k < NC; k++) cmp_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    check("R10 irq", 64'(irq), 0);
    bus_rd(0, d); check("R10 status", 64'(d), 0);
    bus_rd(1, d); check("R10 cnt lo", 64'(d), 0);
    bus_rd(2, d); check("R10 cnt hi", 64'(d), 0);
    for (int k = 0; k < NC; k++) begin
      bus_rd(AW'(4 + k), d); check("R10 cmp", 64'(d), 0);
    end

    // R1 advance and hold
    repeat (10) do_tick();
    bus_rd(1, d); check("R1 lo after ticks", 64'(d), 64'(cnt_m[7:0]));
    repeat (20) @(negedge clk);
    bus_rd(1, d); check("R1 lo held", 64'(d), 64'(cnt_m[7:0]));
    bus_wr(1, 8'h55);
    bus_rd(1, d); check("R2 lo write ignored", 64'(d), 64'(cnt_m[7:0]));

    // R3 compare readback
    for (int k = 0; k < NC; k++) bus_wr(AW'(4 + k), DW'(8'h31 * (k + 1)));
    for (int k = 0; k < NC; k++) begin
      bus_rd(AW'(4 + k), d); check("R3 cmp readback", 64'(d), 64'(cmp_m[k]));
    end

    // move to 0xE0, then arm all channels, some past rollover (R4, R9, R6)
    while (cnt_m[7:0] != 8'hE0) do_tick();
    bus_wr(0, 8'h0F);
    check("R6 clear all", 64'(irq), 0);
    for (int k = 0; k < NC; k++) bus_wr(AW'(4 + k), cnt_m[7:0] + iv[k]);
    for (int t = 0; t < 300; t++) begin
      do_tick();
      check("R4 R9 irq per tick", 64'(irq), 64'(flg_m));
      if (|flg_m) begin
        bus_wr(0, DW'(flg_m));
        check("R6 clear after match", 64'(irq), 0);
      end
    end

    // R2 carry-safe high word
    while (cnt_m[7:0] != 8'hFF) do_tick();
    bus_rd(1, d); check("R2 lo at FF", 64'(d), 8'hFF);
    hsnap = cnt_m[15:8];
    do_tick();
    bus_rd(2, d); check("R2 hi captured", 64'(d), 64'(hsnap));
    bus_rd(1, d); check("R2 lo after carry", 64'(d), 0);
    bus_rd(2, d); check("R2 hi after carry", 64'(d), 64'(cnt_m[15:8]));

    // R8 status read with flags set
    bus_wr(0, 8'h0F);
    bus_wr(5, cnt_m[7:0] + 8'd1);
    bus_wr(6, cnt_m[7:0] + 8'd1);
    do_tick();
    bus_rd(0, d); check("R8 status flags", 64'(d), 64'(flg_m));
    check("R8 ch1 ch2 set", 64'(flg_m[2:1]), 2'b11);

    // R6 zero bits and upper bits ignored
    bus_wr(0, 8'hF0);
    bus_rd(0, d); check("R6 write zero ignored", 64'(d), 64'(flg_m));
    check("R9 irq holds", 64'(irq), 64'(flg_m));

    // R7 set wins over simultaneous clear
    bus_wr(5, cnt_m[7:0] + 8'd1);
    tick_clr(8'h06);
    check("R7 ch1 kept", 64'(irq[1]), 1);
    check("R7 ch2 cleared", 64'(irq[2]), 0);
    bus_rd(0, d); check("R7 status", 64'(d), 64'(flg_m));

    // R5 compare equal to current count, no tick
    bus_wr(0, 8'h0F);
    bus_wr(7, cnt_m[7:0]);
    repeat (10) @(negedge clk);
    bus_rd(0, d); check("R5 no tick no match", 64'(d), 0);
    do_tick();
    check("R5 ch3 silent after tick", 64'(irq[3]), 0);
    check("R9 irq vs model", 64'(irq), 64'(flg_m));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule